// File: doc/BRIEF.md
# Undocumented-Opcode Accumulator ALU

This block is the arithmetic slice that carries out four irregular operations of an 8-bit accumulator processor: a masked AND through the index register (opcode code 0), a masked load into both accumulator and index (code 1), an AND followed by rotate-right with decimal fix-ups (code 2), and subtract-with-borrow with its decimal-mode flag rules (code 3). The core's sequencer presents the current accumulator, index register, immediate operand and the carry, overflow and decimal flags, together with an operation code. It pulses `en` for one cycle, and the block registers the new accumulator, index and N/V/Z/C flags.

Two build-time byte constants set how the first two operations treat the accumulator, because different silicon revisions behave differently there. A build-time switch turns the decimal paths on or off. With the switch off, the decimal flag is ignored and the binary arithmetic is always used. Fetch, addressing and every regular opcode stay with the surrounding core.

Top module: `undoc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero.
- R2: At an edge where `en` is low, all outputs keep their previous values, whatever the other inputs do.
- R3: Code 0 produces accumulator = (a_in OR ANE_MAGIC) AND x_in AND imm_in. N is bit 7 of the result and Z is set when the result is zero. C and V copy c_in and v_in.
- R4: Code 1 produces result = (a_in OR LXA_MAGIC) AND imm_in, and writes it to both the accumulator and the index output. N and Z come from the result, and C and V copy c_in and v_in.
- R5: The decimal paths of codes 2 and 3 are used only when d_in is 1 and DEC_EN is 1. In every other case the binary paths apply.
- R6: Binary code 2 forms t = a_in AND imm_in and rotates t right with c_in entering bit 7. C is result bit 6, V is bit 6 XOR bit 5, N is bit 7, and Z is set when the result is zero.
- R7: In decimal code 2, N equals c_in and Z is set when the unadjusted rotated value is zero. V is bit 6 of t XOR the rotated value.
- R8: In decimal code 2, when t[3:0] + t[0] > 5, the low nibble of the rotated value gains 6 and any nibble carry is dropped. When t[7:4] + t[4] > 5, the high nibble gains 6 and C is set; otherwise C is cleared.
- R9: Binary code 3 produces a_in − imm_in − (1 − c_in) modulo 256. C is 1 exactly when the difference is not negative, and N and Z come from the result.
- R10: In decimal code 3, the low digit difference is lowered by 6 when it goes negative. A negative low part takes 0x10 from the high part, and a negative high part takes a further 0x60. C is set when no borrow remains.
- R11: In decimal code 3, N and Z come from the plain binary difference and not from the adjusted accumulator.
- R12: For code 3 in both modes, V is bit 7 of (a_in XOR imm_in) AND (a_in XOR binary difference).
- R13: Codes 0, 2 and 3 pass x_in unchanged to the index output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Capture enable for one operation |
| op_sel | input | 2 | Operation code: 0 masked AND, 1 masked load, 2 AND-rotate, 3 subtract |
| a_in | input | 8 | Current accumulator |
| x_in | input | 8 | Current index register |
| imm_in | input | 8 | Immediate operand |
| c_in | input | 1 | Carry flag in |
| v_in | input | 1 | Overflow flag in |
| d_in | input | 1 | Decimal flag in |
| a_out | output | 8 | Registered accumulator |
| x_out | output | 8 | Registered index register |
| n_out | output | 1 | Registered negative flag |
| v_out | output | 1 | Registered overflow flag |
| z_out | output | 1 | Registered zero flag |
| c_out | output | 1 | Registered carry flag |

## Verification
The checker assumes that every input is a known value at each edge where `en` is high, and that `rst` stays high for at least one edge before the first operation. It also relies on the fact that any 2-bit code is a legal operation, so it needs no guard for undefined codes. The bench drives every input on the falling edge and starts issuing operations only after reset has been released. It runs a build with the decimal paths enabled and one with them disabled in parallel on the same stimulus, and it sets the decimal flag at random so that the fallback to the binary path is exercised.

// File: rtl/undoc_alu_pkg.sv
package undoc_alu_pkg;

    localparam int DW = 8;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [1:0] {
        UOP_ANE = 2'd0,
        UOP_LXA = 2'd1,
        UOP_ARR = 2'd2,
        UOP_SBC = 2'd3
    } uop_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    typedef struct packed {
        word_t  acc;
        word_t  idx;
        flags_t f;
    } ures_t;

    function automatic flags_t flags_from(word_t r, logic v, logic c);
        flags_t f;
        f.n = r[DW-1];
        f.v = v;
        f.z = (r == '0);
        f.c = c;
        return f;
    endfunction

endpackage

// File: rtl/undoc_mask_unit.sv
module undoc_mask_unit
    import undoc_alu_pkg::*;
#(
    parameter logic [7:0] ANE_MAGIC = 8'hFF,
    parameter logic [7:0] LXA_MAGIC = 8'hFF
) (
    input  logic  is_load,
    input  word_t a,
    input  word_t x,
    input  word_t m,
    input  logic  c,
    input  logic  v,
    output ures_t res
);
    word_t r;

    always_comb begin
        if (is_load) begin
            r       = (a | LXA_MAGIC) & m;
            res.idx = r;
        end else begin
            r       = (a | ANE_MAGIC) & x & m;
            res.idx = x;
        end
        res.acc = r;
        res.f   = flags_from(r, v, c);
    end
endmodule

// File: rtl/undoc_arr_unit.sv
module undoc_arr_unit
    import undoc_alu_pkg::*;
#(
    parameter bit DEC_EN = 1'b1
) (
    input  word_t a,
    input  word_t x,
    input  word_t m,
    input  logic  c,
    input  logic  dec,
    output ures_t res
);
    word_t t;
    word_t rot;
    ures_t res_bin;
    ures_t res_dec;

    always_comb begin
        t   = a & m;
        rot = {c, t[DW-1:1]};
        res_bin.acc = rot;
        res_bin.idx = x;
        res_bin.f.n = rot[7];
        res_bin.f.v = rot[6] ^ rot[5];
        res_bin.f.z = (rot == '0);
        res_bin.f.c = rot[6];
    end

    generate
        if (DEC_EN) begin : g_dec
            logic  lo_fix;
            logic  hi_fix;
            word_t adj;
            always_comb begin
                lo_fix = ({1'b0, t[3:0]} + {4'b0, t[0]}) > 5'd5;
                hi_fix = ({1'b0, t[7:4]} + {4'b0, t[4]}) > 5'd5;
                adj    = rot;
                if (lo_fix) adj[3:0] = rot[3:0] + 4'd6;
                if (hi_fix) adj[7:4] = rot[7:4] + 4'd6;
                res_dec.acc = adj;
                res_dec.idx = x;
                res_dec.f.n = c;
                res_dec.f.v = t[6] ^ rot[6];
                res_dec.f.z = (rot == '0);
                res_dec.f.c = hi_fix;
            end
        end else begin : g_nodec
            assign res_dec = res_bin;
        end
    endgenerate

    assign res = (dec && DEC_EN) ? res_dec : res_bin;
endmodule

// File: rtl/undoc_sbc_unit.sv
module undoc_sbc_unit
    import undoc_alu_pkg::*;
#(
    parameter bit DEC_EN = 1'b1
) (
    input  word_t a,
    input  word_t x,
    input  word_t m,
    input  logic  c,
    input  logic  dec,
    output ures_t res
);
    localparam int WW = 2 * DW;

    logic [DW:0] diff;
    logic        ovf;
    ures_t       res_bin;
    ures_t       res_dec;

    always_comb begin
        diff = {1'b0, a} - {1'b0, m} - {{DW{1'b0}}, ~c};
        ovf  = ((a ^ m) & (a ^ diff[DW-1:0])) >> (DW - 1) != '0;
        res_bin.acc = diff[DW-1:0];
        res_bin.idx = x;
        res_bin.f   = flags_from(diff[DW-1:0], ovf, ~diff[DW]);
    end

    generate
        if (DEC_EN) begin : g_dec
            logic [WW-1:0] lo;
            logic [WW-1:0] hi;
            always_comb begin
                lo = {12'b0, a[3:0]} - {12'b0, m[3:0]} - {{(WW-1){1'b0}}, ~c};
                if (lo[7:4] != 4'b0) lo = lo - 16'd6;
                hi = {8'b0, a[7:4], 4'b0} - {8'b0, m[7:4], 4'b0};
                if (lo[7]) hi = hi - 16'h0010;
                if (hi[11:8] != 4'b0) hi = hi - 16'h0060;
                res_dec.acc = {hi[7:4], lo[3:0]};
                res_dec.idx = x;
                res_dec.f   = flags_from(diff[DW-1:0], ovf, hi[15:8] == 8'b0);
            end
        end else begin : g_nodec
            assign res_dec = res_bin;
        end
    endgenerate

    assign res = (dec && DEC_EN) ? res_dec : res_bin;
endmodule

// File: rtl/undoc_alu.sv
module undoc_alu
    import undoc_alu_pkg::*;
#(
    parameter bit         DEC_EN    = 1'b1,
    parameter logic [7:0] ANE_MAGIC = 8'hFF,
    parameter logic [7:0] LXA_MAGIC = 8'hFF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] op_sel,
    input  logic [7:0] a_in,
    input  logic [7:0] x_in,
    input  logic [7:0] imm_in,
    input  logic       c_in,
    input  logic       v_in,
    input  logic       d_in,
    output logic [7:0] a_out,
    output logic [7:0] x_out,
    output logic       n_out,
    output logic       v_out,
    output logic       z_out,
    output logic       c_out
);
    uop_e  op;
    ures_t r_mask;
    ures_t r_arr;
    ures_t r_sbc;
    ures_t r_sel;
    ures_t r_q;

    assign op = uop_e'(op_sel);

    undoc_mask_unit #(.ANE_MAGIC(ANE_MAGIC), .LXA_MAGIC(LXA_MAGIC)) u_mask (
        .is_load(op == UOP_LXA), .a(a_in), .x(x_in), .m(imm_in),
        .c(c_in), .v(v_in), .res(r_mask)
    );

    undoc_arr_unit #(.DEC_EN(DEC_EN)) u_arr (
        .a(a_in), .x(x_in), .m(imm_in), .c(c_in), .dec(d_in), .res(r_arr)
    );

    undoc_sbc_unit #(.DEC_EN(DEC_EN)) u_sbc (
        .a(a_in), .x(x_in), .m(imm_in), .c(c_in), .dec(d_in), .res(r_sbc)
    );

    always_comb begin
        unique case (op)
            UOP_ARR: r_sel = r_arr;
            UOP_SBC: r_sel = r_sbc;
            default: r_sel = r_mask;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     r_q <= '0;
        else if (en) r_q <= r_sel;
    end

    assign a_out = r_q.acc;
    assign x_out = r_q.idx;
    assign n_out = r_q.f.n;
    assign v_out = r_q.f.v;
    assign z_out = r_q.f.z;
    assign c_out = r_q.f.c;
endmodule

// File: rtl/undoc_alu_chk.sv
module undoc_alu_chk #(
    parameter bit DEC_EN = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic [1:0] op_sel,
    input logic [7:0] x_in,
    input logic       c_in,
    input logic       d_in,
    input logic [7:0] a_out,
    input logic [7:0] x_out,
    input logic       n_out,
    input logic       v_out,
    input logic       z_out,
    input logic       c_out
);
    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rst_seen |-> (a_out == 8'h00 && x_out == 8'h00 && !n_out && !v_out && !z_out && !c_out));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(a_out) && $stable(x_out) && $stable({n_out, v_out, z_out, c_out})));

    // R4
    load_both_chk: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel == 2'd1) |=> (x_out == a_out));

    // R13
    idx_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel != 2'd1) |=> (x_out == $past(x_in)));

    // R3
    ane_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel == 2'd0) |=> ((a_out & ~$past(x_in)) == 8'h00));

    // R5
    binary_nz_chk: assert property (@(posedge clk) disable iff (rst)
        (en && (op_sel[1] == 1'b0 || !(d_in && DEC_EN))) |=> (z_out == (a_out == 8'h00) && n_out == a_out[7]));

    // R7
    dec_arr_n_chk: assert property (@(posedge clk) disable iff (rst)
        (en && op_sel == 2'd2 && d_in && DEC_EN) |=> (n_out == $past(c_in)));
endmodule

bind undoc_alu undoc_alu_chk #(.DEC_EN(DEC_EN)) u_chk (
    .clk(clk), .rst(rst), .en(en), .op_sel(op_sel), .x_in(x_in), .c_in(c_in), .d_in(d_in),
    .a_out(a_out), .x_out(x_out), .n_out(n_out), .v_out(v_out), .z_out(z_out), .c_out(c_out)
);

// File: tb/undoc_alu_bench.sv
`timescale 1ns/1ps
module undoc_alu_bench;
    localparam int CLK_NS = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [1:0] op_sel = '0;
    logic [7:0] a_in = '0, x_in = '0, imm_in = '0;
    logic       c_in = 1'b0, v_in = 1'b0, d_in = 1'b0;
    logic [7:0] a_out, x_out, a_out_b, x_out_b;
    logic       n_out, v_out, z_out, c_out;
    logic       n_out_b, v_out_b, z_out_b, c_out_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [19:0] exp_q[$];
    logic [19:0] expb_q[$];
    string       req_q[$];

    always #(CLK_NS/2) clk = ~clk;

    undoc_alu #(.DEC_EN(1'b1), .ANE_MAGIC(8'hEF), .LXA_MAGIC(8'hFE)) u_undoc_alu (
        .clk(clk), .rst(rst), .en(en), .op_sel(op_sel), .a_in(a_in), .x_in(x_in),
        .imm_in(imm_in), .c_in(c_in), .v_in(v_in), .d_in(d_in),
        .a_out(a_out), .x_out(x_out), .n_out(n_out), .v_out(v_out), .z_out(z_out), .c_out(c_out)
    );

    undoc_alu #(.DEC_EN(1'b0)) u_undoc_alu_bin (
        .clk(clk), .rst(rst), .en(en), .op_sel(op_sel), .a_in(a_in), .x_in(x_in),
        .imm_in(imm_in), .c_in(c_in), .v_in(v_in), .d_in(d_in),
        .a_out(a_out_b), .x_out(x_out_b), .n_out(n_out_b), .v_out(v_out_b), .z_out(z_out_b), .c_out(c_out_b)
    );

    // Reference built from the requirement text: {acc, idx, n, v, z, c}
    function automatic logic [19:0] model(int op, int a, int x, int m, int c, int v, int d,
                                          int dec_en, int ane_k, int lxa_k);
        int ra, rx, fn, fv, fz, fc, t, nx, df, lo, hi;
        ra = 0; rx = x; fv = v; fc = c; fn = 0; fz = 0;
        case (op)
            0: begin ra = (a | ane_k) & x & m; end
            1: begin ra = (a | lxa_k) & m; rx = ra; end
            2: begin
                t  = a & m;
                nx = (t >> 1) | (c << 7);
                if (d != 0 && dec_en != 0) begin
                    fn = c; fz = (nx == 0); fv = ((t ^ nx) >> 6) & 1;
                    if ((t & 15) + (t & 1) > 5) nx = (nx & 'hF0) | ((nx + 6) & 15);
                    if ((t & 'hF0) + (t & 'h10) > 'h50) begin
                        nx = (nx & 15) | ((nx + 'h60) & 'hF0); fc = 1;
                    end else fc = 0;
                    ra = nx;
                end else begin
                    ra = nx; fc = (nx >> 6) & 1; fv = ((nx >> 6) ^ (nx >> 5)) & 1;
                end
            end
            default: begin
                df = a - m - ((c != 0) ? 0 : 1);
                fv = (((a ^ m) & (a ^ df)) >> 7) & 1;
                if (d != 0 && dec_en != 0) begin
                    fn = (df >> 7) & 1; fz = ((df & 255) == 0);
                    lo = (a & 15) - (m & 15) - ((c != 0) ? 0 : 1);
                    if ((lo & 'hF0) != 0) lo -= 6;
                    hi = (a & 'hF0) - (m & 'hF0);
                    if ((lo & 'h80) != 0) hi -= 'h10;
                    if ((hi & 'hF00) != 0) hi -= 'h60;
                    fc = ((hi & 'hFF00) == 0);
                    ra = (lo & 15) | (hi & 'hF0);
                end else begin
                    ra = df & 255; fc = (df >= 0);
                end
            end
        endcase
        if (!(op >= 2 && d != 0 && dec_en != 0)) begin
            fn = (ra >> 7) & 1; fz = ((ra & 255) == 0);
        end
        return {ra[7:0], rx[7:0], fn[0], fv[0], fz[0], fc[0]};
    endfunction

    task automatic check(string req, logic [19:0] got, logic [19:0] expv);
        checks++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s got=%05h exp=%05h", req, got, expv);
        end
    endtask

    task automatic drive(int op, int a, int x, int m, int c, int v, int d);
        @(negedge clk);
        op_sel = op[1:0]; a_in = a[7:0]; x_in = x[7:0]; imm_in = m[7:0];
        c_in = c[0]; v_in = v[0]; d_in = d[0]; en = 1'b1;
    endtask

    task automatic issue(string req, int op, int a, int x, int m, int c, int v, int d);
        drive(op, a, x, m, c, v, d);
        exp_q.push_back(model(op, a, x, m, c, v, d, 1, 'hEF, 'hFE));
        expb_q.push_back(model(op, a, x, m, c, v, d, 0, 'hFF, 'hFF));
        req_q.push_back(req);
    endtask

    task automatic issue_known(string req, int op, int a, int x, int m, int c, int v, int d,
                               logic [19:0] e_main);
        drive(op, a, x, m, c, v, d);
        exp_q.push_back(e_main);
        expb_q.push_back(model(op, a, x, m, c, v, d, 0, 'hFF, 'hFF));
        req_q.push_back(req);
    endtask

    // Monitor: an operation captured at an edge is compared on the following falling edge
    initial begin
        forever begin
            bit fire;
            @(posedge clk);
            fire = en && !rst;
            @(negedge clk);
            if (fire && exp_q.size() > 0) begin
                string r;
                r = req_q.pop_front();
                check(r, {a_out, x_out, n_out, v_out, z_out, c_out}, exp_q.pop_front());
                check({r, "/R5 binary build"},
                      {a_out_b, x_out_b, n_out_b, v_out_b, z_out_b, c_out_b}, expb_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [19:0] held;
        repeat (3) @(negedge clk);
        // R1: outputs zero during reset
        check("R1", {a_out, x_out, n_out, v_out, z_out, c_out}, 20'h0);
        rst = 1'b0;

        // R3: masked AND with the non-default constant 0xEF
        issue_known("R3", 0, 'h00, 'hFF, 'hFF, 1, 1, 0, {8'hEF, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1});
        issue_known("R3", 0, 'h00, 'hF0, 'h3C, 0, 0, 1, {8'h20, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b0});
        issue_known("R3", 0, 'h10, 'h0F, 'hF0, 0, 0, 0, {8'h00, 8'h0F, 1'b0, 1'b0, 1'b1, 1'b0});
        // R4: masked load with 0xFE, result also in index
        issue_known("R4", 1, 'h00, 'h33, 'hFF, 0, 1, 0, {8'hFE, 8'hFE, 1'b1, 1'b1, 1'b0, 1'b0});
        issue_known("R4", 1, 'h01, 'h33, 'hFF, 1, 0, 0, {8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1});
        // R6: binary AND-rotate, C from bit 6
        issue_known("R6", 2, 'hC0, 'h55, 'hFF, 0, 0, 0, {8'h60, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1});
        issue_known("R6", 2, 'h01, 'h00, 'h01, 0, 1, 0, {8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0});
        // R7 R8: decimal AND-rotate with both fix-ups
        issue_known("R8", 2, 'hFF, 'h12, 'hFF, 1, 0, 1, {8'h55, 8'h12, 1'b1, 1'b0, 1'b0, 1'b1});
        issue_known("R7", 2, 'h01, 'h00, 'h01, 0, 0, 1, {8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0});
        // R9: binary subtract
        issue_known("R9", 3, 'h50, 'h00, 'h10, 1, 0, 0, {8'h40, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1});
        issue_known("R9", 3, 'h00, 'h00, 'h00, 0, 0, 0, {8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0});
        // R10 R11: decimal 00 - 01 gives 99, N from binary FF
        issue_known("R10", 3, 'h00, 'h07, 'h01, 1, 0, 1, {8'h99, 8'h07, 1'b1, 1'b0, 1'b0, 1'b0});
        issue_known("R11", 3, 'h10, 'h07, 'h10, 1, 0, 1, {8'h00, 8'h07, 1'b0, 1'b0, 1'b1, 1'b1});
        // R12: signed overflow 0x80 - 0x01
        issue_known("R12", 3, 'h80, 'h00, 'h01, 1, 0, 0, {8'h7F, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1});

        // R2: enable low, inputs change, outputs hold
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        held = {a_out, x_out, n_out, v_out, z_out, c_out};
        op_sel = 2'd1; a_in = 8'h5A; x_in = 8'hA5; imm_in = 8'hFF; c_in = 1'b1; d_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R2", {a_out, x_out, n_out, v_out, z_out, c_out}, held);

        // R3..R13 under random operands, decimal flag random (R5)
        for (int i = 0; i < 1600; i++) begin
            string tag;
            int op;
            op = i % 4;
            case (op)
                0: tag = "R3/R13 random";
                1: tag = "R4 random";
                2: tag = "R6/R7/R8 random";
                default: tag = "R9/R10/R11/R12 random";
            endcase
            issue(tag, op, $urandom_range(255), $urandom_range(255), $urandom_range(255),
                  $urandom_range(1), $urandom_range(1), $urandom_range(1));
        end
        @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset in the middle of operation clears again
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run", {a_out, x_out, n_out, v_out, z_out, c_out}, 20'h0);
        rst = 1'b0;
        @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule